// File: doc/BRIEF.md
# Disk Controller Data Buffer

This block is the byte buffer between a host data port and the byte-serial disk stream of a floppy-style disk controller. The host moves bytes with read and write strobes on an 8-bit bus. The disk side takes or delivers one byte on each `diskTick` pulse. After reset the buffer behaves as a single-byte register. A configure strobe turns it into a FIFO of `DEPTH` bytes and sets a threshold. The service request `svcReq` then rises early enough that the host can tolerate a long servicing latency. The allowed latency is the threshold times the byte period (4, 8 or 16 µs at 2 Mbps, 1 Mbps or 500 kbps), less 1.5 µs.

A pulse on `execStart` begins the execution phase of a transfer, in the direction given by `execDirRead`. That pulse also empties the buffer. In the read direction the disk fills the buffer and the host drains it. If a disk byte finds the buffer full, this is an overrun: the transfer ends, and the host removes what is left. In the write direction the host fills the buffer and the disk drains it. If the disk asks for a byte from an empty buffer, this is an underrun: the rest of the sector is sent as zero bytes. A write sector, whether complete or padded, is always followed by its two CRC bytes.

Top module: `disk_data_buffer`

## Requirements
- R1: After reset the buffer holds at most one byte. In a write transfer, a second host write made before the disk takes the first byte is dropped, and `svcReq` is high only while the buffer is empty.
- R2: A `cfgLoad` pulse with `cfgFifoEn`=1 selects FIFO operation with `DEPTH` bytes of storage and latches `cfgThresh` as the threshold. A threshold value of 0 is treated as 1.
- R3: During a write transfer, `svcReq` is high while the number of stored bytes is at or below the threshold. In single-byte mode the threshold is 0.
- R4: During a read transfer, `svcReq` is high while the buffer is not empty and the free space is at or below the threshold. Once the transfer has ended, `svcReq` is high whenever any byte remains.
- R5: An `execStart` pulse empties the buffer, clears `overrunFlag` and `underrunFlag`, and restarts the sector byte count.
- R6: In a read transfer, a `diskTick` that finds the buffer full is dropped. It sets `overrunFlag` and ends the transfer (`busy` low). The host can still read every stored byte.
- R7: In a write transfer, a `diskTick` that finds the buffer empty sets `underrunFlag`. That byte and every remaining byte of the sector are sent as 0x00, and host writes are ignored for the rest of the transfer.
- R8: After `SECTOR_BYTES` bytes of a write sector, the next two ticks send the CRC-16 of all bytes sent, including padding. The CRC uses polynomial 0x1021 with preset 0xFFFF, processes each byte most significant bit first, and is sent high byte first. `diskOutCrc` is high for these two bytes, and `busy` then goes low.
- R9: Each write-direction `diskTick` produces `diskOutValid` for exactly the following cycle, with the byte on `diskOutData`.
- R10: Bytes leave the buffer in the order they entered, in both directions, and it never holds more than `DEPTH` bytes.
- R11: A read transfer ends (`busy` low) after `SECTOR_BYTES` disk bytes. Later ticks store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Configure strobe |
| cfgFifoEn | input | 1 | 1 = FIFO operation, 0 = single byte |
| cfgThresh | input | $clog2(DEPTH) | Service threshold (0 read as 1) |
| execStart | input | 1 | Starts execution phase, empties buffer |
| execDirRead | input | 1 | Direction latched at `execStart`: 1 = disk read |
| hostWr | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write byte |
| hostRd | input | 1 | Host read strobe (takes the head byte) |
| hostRdData | output | 8 | Head byte of the buffer |
| svcReq | output | 1 | Service request to host |
| diskTick | input | 1 | One disk byte period elapsed |
| diskInData | input | 8 | Byte from the disk (read direction) |
| diskOutValid | output | 1 | Byte presented to the disk |
| diskOutData | output | 8 | Byte to the disk |
| diskOutCrc | output | 1 | Presented byte is a CRC byte |
| busy | output | 1 | Execution phase running |
| overrunFlag | output | 1 | Read overrun occurred |
| underrunFlag | output | 1 | Write underrun occurred |

## Verification
The bench builds the block with `DEPTH`=16 and `SECTOR_BYTES`=20. With these values a complete sector is longer than the buffer, so one transfer can fill the buffer to the brim, overrun it, and still need refilling before the CRC is sent. Thresholds of 3, 4 and 0 (read as 1) put the request edges at stored-byte counts that a few dozen ticks can reach. The short sector keeps zero padding followed by CRC checking to about twenty ticks per case.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

  typedef enum logic [1:0] {
    EMIT_FIFO   = 2'd0,
    EMIT_ZERO   = 2'd1,
    EMIT_CRC_HI = 2'd2,
    EMIT_CRC_LO = 2'd3
  } emit_sel_t;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_XFER   = 3'd1,
    PH_FILL   = 3'd2,
    PH_CRC_HI = 3'd3,
    PH_CRC_LO = 3'd4
  } phase_t;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic      flush;
    logic      push;
    logic      pushFromDisk;
    logic      pop;
    logic      emit;
    emit_sel_t emitSel;
  } dp_strobe_t;

  // One byte through CRC-16, polynomial 0x1021, MSB first.
  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

endpackage

// File: rtl/dbuf_dpath.sv
module dbuf_dpath
  import dbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dp_strobe_t    strb,
  input  logic [7:0]    hostWrData,
  input  logic [7:0]    diskInData,
  output logic [CW-1:0] count,
  output logic [7:0]    headData,
  output logic [7:0]    diskOutData,
  output logic          diskOutValid,
  output logic          diskOutCrc
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [15:0]   crcReg;
  logic [7:0]    pushByte;
  logic [7:0]    emitByte;

  function automatic logic [AW-1:0] ptrNext(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pushByte = strb.pushFromDisk ? diskInData : hostWrData;
  assign headData = mem[rdPtr];

  always_comb begin
    unique case (strb.emitSel)
      EMIT_FIFO:   emitByte = headData;
      EMIT_ZERO:   emitByte = 8'h00;
      EMIT_CRC_HI: emitByte = crcReg[15:8];
      default:     emitByte = crcReg[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (strb.push && !strb.flush) mem[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= ptrNext(wrPtr);
      if (strb.pop)  rdPtr <= ptrNext(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg       <= 16'hFFFF;
      diskOutData  <= 8'h00;
      diskOutValid <= 1'b0;
      diskOutCrc   <= 1'b0;
    end else begin
      diskOutValid <= strb.emit && !strb.flush;
      if (strb.flush) begin
        crcReg     <= 16'hFFFF;
        diskOutCrc <= 1'b0;
      end else if (strb.emit) begin
        diskOutData <= emitByte;
        diskOutCrc  <= strb.emitSel inside {EMIT_CRC_HI, EMIT_CRC_LO};
        if (strb.emitSel inside {EMIT_FIFO, EMIT_ZERO})
          crcReg <= crcStep(crcReg, emitByte);
      end
    end
  end

endmodule

// File: rtl/dbuf_ctrl.sv
module dbuf_ctrl
  import dbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SECTOR_BYTES = 512,
  localparam int THW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(SECTOR_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgLoad,
  input  logic           cfgFifoEn,
  input  logic [THW-1:0] cfgThresh,
  input  logic           execStart,
  input  logic           execDirRead,
  input  logic           hostWr,
  input  logic           hostRd,
  input  logic           diskTick,
  input  logic [CW-1:0]  count,
  output dp_strobe_t     strb,
  output logic           svcReq,
  output logic           busy,
  output logic           overrunFlag,
  output logic           underrunFlag
);

  logic           fifoEn;
  logic [THW-1:0] thrReg;
  phase_t         phase;
  logic           dirRead;
  logic [SW-1:0]  byteIdx;

  logic [CW-1:0]  capEff, thrEff, freeCnt;
  logic           full, empty, lastByte;

  assign capEff   = fifoEn ? CW'(DEPTH) : CW'(1);
  assign thrEff   = fifoEn ? CW'(thrReg) : '0;
  assign freeCnt  = capEff - count;
  assign full     = count >= capEff;
  assign empty    = count == '0;
  assign lastByte = byteIdx == SW'(SECTOR_BYTES - 1);
  assign busy     = phase != PH_IDLE;

  // Configuration: single-byte after reset, threshold clamped to 1..DEPTH-1.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoEn <= 1'b0;
      thrReg <= THW'(1);
    end else if (cfgLoad) begin
      fifoEn <= cfgFifoEn;
      thrReg <= (cfgThresh == '0) ? THW'(1) : cfgThresh;
    end
  end

  // Strobe generation.
  always_comb begin
    strb         = '0;
    strb.emitSel = EMIT_FIFO;
    if (execStart) begin
      strb.flush = 1'b1;
    end else if (dirRead) begin
      if (hostRd && !empty) strb.pop = 1'b1;
      if (diskTick && phase == PH_XFER && !full) begin
        strb.push         = 1'b1;
        strb.pushFromDisk = 1'b1;
      end
    end else begin
      if (hostWr && phase == PH_XFER && !full) strb.push = 1'b1;
      if (diskTick && busy) begin
        strb.emit = 1'b1;
        unique case (phase)
          PH_XFER: begin
            if (empty) strb.emitSel = EMIT_ZERO;
            else begin
              strb.emitSel = EMIT_FIFO;
              strb.pop     = 1'b1;
            end
          end
          PH_FILL:   strb.emitSel = EMIT_ZERO;
          PH_CRC_HI: strb.emitSel = EMIT_CRC_HI;
          default:   strb.emitSel = EMIT_CRC_LO;
        endcase
      end
    end
  end

  // Phase sequencing and error flags.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase        <= PH_IDLE;
      dirRead      <= 1'b0;
      byteIdx      <= '0;
      overrunFlag  <= 1'b0;
      underrunFlag <= 1'b0;
    end else if (execStart) begin
      phase        <= PH_XFER;
      dirRead      <= execDirRead;
      byteIdx      <= '0;
      overrunFlag  <= 1'b0;
      underrunFlag <= 1'b0;
    end else if (diskTick) begin
      unique case (phase)
        PH_XFER: begin
          if (dirRead) begin
            if (full) begin
              overrunFlag <= 1'b1;
              phase       <= PH_IDLE;
            end else begin
              byteIdx <= byteIdx + 1'b1;
              if (lastByte) phase <= PH_IDLE;
            end
          end else begin
            byteIdx <= byteIdx + 1'b1;
            if (empty) underrunFlag <= 1'b1;
            if (lastByte)   phase <= PH_CRC_HI;
            else if (empty) phase <= PH_FILL;
          end
        end
        PH_FILL: begin
          byteIdx <= byteIdx + 1'b1;
          if (lastByte) phase <= PH_CRC_HI;
        end
        PH_CRC_HI: phase <= PH_CRC_LO;
        PH_CRC_LO: phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  // Service request.
  always_comb begin
    if (dirRead) svcReq = !empty && (phase == PH_IDLE || freeCnt <= thrEff);
    else         svcReq = (phase == PH_XFER) && (count <= thrEff);
  end

endmodule

// File: rtl/disk_data_buffer.sv
module disk_data_buffer
  import dbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int SECTOR_BYTES = 512,
  localparam int THW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgLoad,
  input  logic           cfgFifoEn,
  input  logic [THW-1:0] cfgThresh,
  input  logic           execStart,
  input  logic           execDirRead,
  input  logic           hostWr,
  input  logic [7:0]     hostWrData,
  input  logic           hostRd,
  output logic [7:0]     hostRdData,
  output logic           svcReq,
  input  logic           diskTick,
  input  logic [7:0]     diskInData,
  output logic           diskOutValid,
  output logic [7:0]     diskOutData,
  output logic           diskOutCrc,
  output logic           busy,
  output logic           overrunFlag,
  output logic           underrunFlag
);

  localparam int CW = $clog2(DEPTH + 1);

  dp_strobe_t    strb;
  logic [CW-1:0] dpCount;

  dbuf_ctrl #(.DEPTH(DEPTH), .SECTOR_BYTES(SECTOR_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cfgLoad(cfgLoad), .cfgFifoEn(cfgFifoEn), .cfgThresh(cfgThresh),
    .execStart(execStart), .execDirRead(execDirRead),
    .hostWr(hostWr), .hostRd(hostRd), .diskTick(diskTick),
    .count(dpCount), .strb(strb), .svcReq(svcReq), .busy(busy),
    .overrunFlag(overrunFlag), .underrunFlag(underrunFlag)
  );

  dbuf_dpath #(.DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostWrData(hostWrData), .diskInData(diskInData),
    .count(dpCount), .headData(hostRdData),
    .diskOutData(diskOutData), .diskOutValid(diskOutValid),
    .diskOutCrc(diskOutCrc)
  );

endmodule

// File: rtl/disk_data_buffer_chk.sv
module disk_data_buffer_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          execStart,
  input logic          diskTick,
  input logic          busy,
  input logic          overrunFlag,
  input logic          underrunFlag,
  input logic          diskOutValid,
  input logic [7:0]    diskOutData,
  input logic          diskOutCrc,
  input logic [CW-1:0] count
);

  // R5: start of execution leaves an empty buffer and clear flags
  a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    execStart |=> (count == '0 && !overrunFlag && !underrunFlag));

  // R6: an overrun ends the transfer in the same cycle it is flagged
  a_r6_overrun_halts: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> !busy);

  // R7: after an underrun every non-CRC byte sent is zero
  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    (underrunFlag && diskOutValid && !diskOutCrc) |-> diskOutData == 8'h00);

  // R9: an output byte appears only the cycle after a tick
  a_r9_valid_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    diskOutValid |-> $past(diskTick));

  // R10: storage never exceeds its depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

endmodule

bind disk_data_buffer disk_data_buffer_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .execStart(execStart), .diskTick(diskTick),
  .busy(busy), .overrunFlag(overrunFlag), .underrunFlag(underrunFlag),
  .diskOutValid(diskOutValid), .diskOutData(diskOutData),
  .diskOutCrc(diskOutCrc), .count(dpCount)
);

// File: tb/disk_data_buffer_tb_top.sv
module disk_data_buffer_tb_top;

  localparam int DEPTH = 16;
  localparam int SECT  = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgLoad = 1'b0, cfgFifoEn = 1'b0;
  logic [3:0] cfgThresh = 4'd0;
  logic       execStart = 1'b0, execDirRead = 1'b0;
  logic       hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWrData = 8'h00, diskInData = 8'h00;
  logic [7:0] hostRdData, diskOutData;
  logic       svcReq, diskTick = 1'b0, diskOutValid, diskOutCrc;
  logic       busy, overrunFlag, underrunFlag;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [15:0] crcExp;

  always #2.5 clk = ~clk;

  disk_data_buffer #(.DEPTH(DEPTH), .SECTOR_BYTES(SECT)) dut_i (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgFifoEn(cfgFifoEn),
    .cfgThresh(cfgThresh), .execStart(execStart), .execDirRead(execDirRead),
    .hostWr(hostWr), .hostWrData(hostWrData), .hostRd(hostRd),
    .hostRdData(hostRdData), .svcReq(svcReq), .diskTick(diskTick),
    .diskInData(diskInData), .diskOutValid(diskOutValid),
    .diskOutData(diskOutData), .diskOutCrc(diskOutCrc), .busy(busy),
    .overrunFlag(overrunFlag), .underrunFlag(underrunFlag)
  );

  function automatic logic [15:0] crcRef(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic configure(input bit en, input logic [3:0] thr);
    @(negedge clk); cfgLoad = 1'b1; cfgFifoEn = en; cfgThresh = thr;
    @(negedge clk); cfgLoad = 1'b0;
  endtask

  task automatic start(input bit rd);
    @(negedge clk); execStart = 1'b1; execDirRead = rd;
    @(negedge clk); execStart = 1'b0;
    crcExp = 16'hFFFF;
  endtask

  task automatic hwrite(input logic [7:0] b);
    @(negedge clk); hostWr = 1'b1; hostWrData = b;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] exp, input string req);
    @(negedge clk);
    check(hostRdData == exp, req, hostRdData, exp);
    hostRd = 1'b1;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic dtick(input logic [7:0] d);
    @(negedge clk); diskTick = 1'b1; diskInData = d;
    @(negedge clk); diskTick = 1'b0;
  endtask

  // Tick in write direction, check emitted data byte (R9), fold into CRC.
  task automatic wtick(input logic [7:0] exp, input string req);
    dtick(8'h00);
    check(diskOutValid && !diskOutCrc, "R9 valid", {diskOutValid, diskOutCrc}, 2);
    check(diskOutData == exp, req, diskOutData, exp);
    crcExp = crcRef(crcExp, exp);
  endtask

  task automatic crc_tail();
    dtick(8'h00);
    check(diskOutValid && diskOutCrc && diskOutData == crcExp[15:8], "R8 crc hi",
          diskOutData, crcExp[15:8]);
    dtick(8'h00);
    check(diskOutValid && diskOutCrc && diskOutData == crcExp[7:0], "R8 crc lo",
          diskOutData, crcExp[7:0]);
    check(!busy, "R8 busy low after crc", busy, 0);
  endtask

  task automatic t_reset();
    check(!busy && !svcReq && !overrunFlag && !underrunFlag, "R1 reset state",
          {busy, svcReq, overrunFlag, underrunFlag}, 0);
  endtask

  // R1 single-byte write, R7 padding, R8 trailer
  task automatic t_single_write();
    start(1'b0);
    check(svcReq, "R1 R3 req when empty", svcReq, 1);
    hwrite(8'hA5);
    check(!svcReq, "R1 req drops at one byte", svcReq, 0);
    hwrite(8'h3C);
    wtick(8'hA5, "R1 first byte sent");
    check(svcReq && !underrunFlag, "R3 req after drain", svcReq, 1);
    wtick(8'h00, "R1 R7 second write dropped, zero sent");
    check(underrunFlag, "R7 underrun flag", underrunFlag, 1);
    hwrite(8'h77);
    for (int i = 2; i < SECT; i++) wtick(8'h00, "R7 zero padding");
    crc_tail();
  endtask

  // R2 R3 R10 FIFO write with threshold 4
  task automatic t_fifo_write();
    configure(1'b1, 4'd4);
    start(1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      hwrite(8'h10 + 8'(i));
      check(svcReq == (i + 1 <= 4), "R2 R3 write request level", svcReq, (i + 1 <= 4));
    end
    for (int i = 0; i < DEPTH; i++) wtick(8'h10 + 8'(i), "R10 write order");
    for (int i = 0; i < SECT - DEPTH; i++) hwrite(8'h40 + 8'(i));
    for (int i = 0; i < SECT - DEPTH; i++) wtick(8'h40 + 8'(i), "R10 refill order");
    check(!underrunFlag && busy, "R7 no underrun when fed", underrunFlag, 0);
    crc_tail();
  endtask

  // R4 R6 read overrun with threshold 3
  task automatic t_read_overrun();
    configure(1'b1, 4'd3);
    start(1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      dtick(8'h80 + 8'(i));
      check(svcReq == (i + 1 >= DEPTH - 3), "R4 read request level", svcReq,
            (i + 1 >= DEPTH - 3));
    end
    check(busy && !overrunFlag, "R6 full without overrun", overrunFlag, 0);
    dtick(8'hFF);
    check(overrunFlag && !busy, "R6 overrun ends transfer", {overrunFlag, busy}, 2);
    for (int i = 0; i < DEPTH; i++) begin
      check(svcReq, "R4 R6 drain request", svcReq, 1);
      hread(8'h80 + 8'(i), "R6 R10 drain order");
    end
    check(!svcReq, "R6 empty after drain", svcReq, 0);
  endtask

  // R2 clamp, R11 sector end, R5 flag clear
  task automatic t_read_sector();
    configure(1'b1, 4'd0);
    start(1'b1);
    check(!overrunFlag, "R5 overrun cleared", overrunFlag, 0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      dtick(8'hC0 + 8'(i));
      if (i == DEPTH - 3) check(!svcReq, "R2 clamp: low at free 2", svcReq, 0);
    end
    check(svcReq, "R2 clamp: high at free 1", svcReq, 1);
    for (int i = 0; i < DEPTH - 1; i++) hread(8'hC0 + 8'(i), "R10 read order");
    for (int i = 0; i < SECT - DEPTH + 1; i++) begin
      dtick(8'hD0 + 8'(i));
      if (i == SECT - DEPTH - 1) check(busy, "R11 busy before last", busy, 1);
    end
    check(!busy && svcReq && !overrunFlag, "R11 sector end", {busy, svcReq}, 1);
    dtick(8'hEE);
    for (int i = 0; i < SECT - DEPTH + 1; i++) hread(8'hD0 + 8'(i), "R11 tail order");
    check(!svcReq, "R11 extra tick not stored", svcReq, 0);
  endtask

  // R5 flush of pending write data
  task automatic t_flush();
    configure(1'b1, 4'd4);
    start(1'b0);
    hwrite(8'h11); hwrite(8'h22); hwrite(8'h33);
    start(1'b0);
    check(svcReq && !underrunFlag, "R5 empty after restart", svcReq, 1);
    wtick(8'h00, "R5 flushed bytes not sent");
    check(underrunFlag, "R5 R7 underrun on flushed buffer", underrunFlag, 1);
    hwrite(8'h55);
    wtick(8'h00, "R7 host write ignored after underrun");
    for (int i = 2; i < SECT; i++) wtick(8'h00, "R7 zero padding");
    crc_tail();
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_write();
    t_fifo_write();
    t_read_overrun();
    t_read_sector();
    t_flush();
    repeat (3) @(negedge clk);
    report();
  end

endmodule